// File: doc/BRIEF.md
# Write-Only Two-Wire Bus Receiver

This block is a receive-only slave for an I2C-compatible two-wire bus. It samples the bus clock and data lines on a much faster system clock. From those samples it recognises START, repeated START and STOP conditions. It collects address and data bytes, most significant bit first. To acknowledge, it asserts an open-drain pull-low enable for the data line.

The slave address has seven bits. The upper five bits are fixed at 10101. The lower two bits come from a static strap input, so up to four copies of the block can share one bus. Only write transfers (R/W bit 0) are acknowledged. Any other address byte leaves the data line released, and the block then ignores the bus until the next START or STOP.

Each accepted data byte is handed to the surrounding logic with a one-cycle valid strobe. A flag marks the first byte after an address match, and a one-cycle pulse reports a STOP that ends an addressed transfer. The block never drives the bus clock and does not interpret the meaning of the bytes it receives.

Top module: `i2cw_rx_slave`

## Requirements
- R1: While synchronous reset is high and in the cycle after it, sdaPullLow, byteValid and frameStop are 0. A STOP seen after a reset produces no frameStop pulse.
- R2: After a START, an address byte equal to {1,0,1,0,1,addrStrap[1],addrStrap[0],0} (MSB first, bit 0 being R/W) is acknowledged. The block pulls SDA low throughout the ninth clock.
- R3: An address byte with a different address, or with R/W bit 1, is not acknowledged. Data bytes that follow it are neither acknowledged nor strobed until the next START or STOP.
- R4: Each data byte of an addressed transfer appears on byteData, MSB first on the wire, together with a byteValid pulse exactly one system clock cycle long.
- R5: Every data byte of an addressed transfer is acknowledged by pulling SDA low during its ninth clock.
- R6: firstByte is 1 together with byteValid for the first data byte after an address match, and 0 for the data bytes that follow it.
- R7: A STOP that ends an addressed transfer yields one frameStop pulse one cycle long. A STOP with no matching address yields none.
- R8: A repeated START restarts address reception without a frameStop pulse. A new match re-arms firstByte. A non-matching address after a repeated START is not acknowledged.
- R9: A START or STOP that arrives before the eighth bit of a byte has been clocked in discards that byte without a byteValid pulse.
- R10: sdaPullLow changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10 times the bus clock rate |
| rst | input | 1 | Synchronous reset, active high |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| addrStrap | input | 2 | Strap bits forming the two low address bits |
| sdaPullLow | output | 1 | When 1, the open-drain driver pulls SDA low |
| byteData | output | 8 | Received data byte, valid while byteValid is 1 |
| byteValid | output | 1 | One-cycle strobe for a received data byte |
| firstByte | output | 1 | Marks the first data byte after an address match |
| frameStop | output | 1 | One-cycle pulse when STOP ends an addressed transfer |

## Verification
The address decoder is swept with every 7-bit address for one strap setting. Each address byte is followed by a data byte, so the acknowledge and strobe results show that exactly one address is accepted and that the rest are ignored. Every strap setting is then tried against all four addresses that share the fixed prefix, plus the read variant of its own address. This separates the strap-bit comparison from the prefix and R/W checks. Directed frames cover several bytes with all-zero and all-one patterns, repeated STARTs to matching and non-matching addresses, STARTs and STOPs in the middle of a byte, and a reset during the acknowledge clock. These frames distinguish the first-byte flag, the stop pulse and the abort rules.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

  // Strobes from the control FSM into the datapath
  typedef struct packed {
    logic shiftEn;
    logic clrCnt;
  } ctlStrobes_t;

  // Bus events and decode results from the datapath
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic byteFull;
    logic addrHit;
  } busEvents_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_SKIP
  } rxState_t;

endpackage

// File: rtl/i2cw_datapath.sv
module i2cw_datapath
  import i2cw_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W = 8,
  parameter int PREFIX_W = 5,
  parameter int STRAP_W = 2,
  parameter logic [PREFIX_W-1:0] PREFIX = 5'b10101
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] strap,
  input  ctlStrobes_t        ctl,
  output busEvents_t         ev,
  output logic [DATA_W-1:0]  shiftData,
  output logic               sclLevel
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic sclNow, sdaNow, sclPrev, sdaPrev;
  logic [DATA_W-1:0] shReg;
  logic [CNT_W-1:0] bitCnt;

  // Synchronizer chain; idle bus level is high
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) begin
          sclPipe[0] <= 1'b1;
          sdaPipe[0] <= 1'b1;
        end else begin
          sclPipe[0] <= sclIn;
          sdaPipe[0] <= sdaIn;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) begin
          sclPipe[g] <= 1'b1;
          sdaPipe[g] <= 1'b1;
        end else begin
          sclPipe[g] <= sclPipe[g-1];
          sdaPipe[g] <= sdaPipe[g-1];
        end
      end
    end
  end

  assign sclNow = sclPipe[SYNC_STAGES-1];
  assign sdaNow = sdaPipe[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shReg  <= '0;
      bitCnt <= '0;
    end else if (ctl.clrCnt) begin
      bitCnt <= '0;
    end else if (ctl.shiftEn && ev.sclRise && (bitCnt != CNT_W'(DATA_W))) begin
      shReg  <= {shReg[DATA_W-2:0], sdaNow};
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    ev.sclRise   = sclNow & ~sclPrev;
    ev.sclFall   = ~sclNow & sclPrev;
    ev.startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
    ev.stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;
    ev.byteFull  = (bitCnt == CNT_W'(DATA_W));
    ev.addrHit   = (shReg == {PREFIX, strap, 1'b0});
  end

  assign shiftData = shReg;
  assign sclLevel  = sclNow;

endmodule

// File: rtl/i2cw_control.sv
module i2cw_control
  import i2cw_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  busEvents_t  ev,
  output ctlStrobes_t ctl,
  output logic        ackDrive,
  output logic        byteValid,
  output logic        firstByte,
  output logic        frameStop
);
  rxState_t state;
  logic firstPend;
  logic addressed;

  assign addressed = (state == ST_ADDR_ACK) || (state == ST_DATA) || (state == ST_DATA_ACK);

  always_comb begin
    ctl.shiftEn = (state == ST_ADDR) || (state == ST_DATA);
    ctl.clrCnt  = ev.startSeen ||
                  (ev.sclFall && ((state == ST_ADDR_ACK) || (state == ST_DATA_ACK)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ackDrive  <= 1'b0;
      byteValid <= 1'b0;
      firstByte <= 1'b0;
      frameStop <= 1'b0;
      firstPend <= 1'b0;
    end else begin
      byteValid <= 1'b0;
      firstByte <= 1'b0;
      frameStop <= 1'b0;
      if (ev.startSeen) begin
        state    <= ST_ADDR;
        ackDrive <= 1'b0;
      end else if (ev.stopSeen) begin
        frameStop <= addressed;
        state     <= ST_IDLE;
        ackDrive  <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (ev.sclFall && ev.byteFull) begin
              if (ev.addrHit) begin
                state     <= ST_ADDR_ACK;
                ackDrive  <= 1'b1;
                firstPend <= 1'b1;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (ev.sclFall) begin
              state    <= ST_DATA;
              ackDrive <= 1'b0;
            end
          end
          ST_DATA: begin
            if (ev.sclFall && ev.byteFull) begin
              byteValid <= 1'b1;
              firstByte <= firstPend;
              firstPend <= 1'b0;
              ackDrive  <= 1'b1;
              state     <= ST_DATA_ACK;
            end
          end
          ST_DATA_ACK: begin
            if (ev.sclFall) begin
              state    <= ST_DATA;
              ackDrive <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2cw_rx_slave.sv
module i2cw_rx_slave
  import i2cw_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W = 8,
  parameter int PREFIX_W = 5,
  parameter int STRAP_W = 2,
  parameter logic [PREFIX_W-1:0] PREFIX = 5'b10101
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] addrStrap,
  output logic               sdaPullLow,
  output logic [DATA_W-1:0]  byteData,
  output logic               byteValid,
  output logic               firstByte,
  output logic               frameStop
);
  ctlStrobes_t ctl;
  busEvents_t  ev;
  logic        sclLvl;

  i2cw_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .DATA_W(DATA_W),
    .PREFIX_W(PREFIX_W),
    .STRAP_W(STRAP_W),
    .PREFIX(PREFIX)
  ) dp_i (
    .clk(clk),
    .rst(rst),
    .sclIn(sclIn),
    .sdaIn(sdaIn),
    .strap(addrStrap),
    .ctl(ctl),
    .ev(ev),
    .shiftData(byteData),
    .sclLevel(sclLvl)
  );

  i2cw_control ctl_i (
    .clk(clk),
    .rst(rst),
    .ev(ev),
    .ctl(ctl),
    .ackDrive(sdaPullLow),
    .byteValid(byteValid),
    .firstByte(firstByte),
    .frameStop(frameStop)
  );

endmodule

// File: rtl/i2cw_rx_checker.sv
module i2cw_rx_checker (
  input logic clk,
  input logic rst,
  input logic sclLvl,
  input logic sdaPullLow,
  input logic byteValid,
  input logic firstByte,
  input logic frameStop
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!sdaPullLow && !byteValid && !frameStop));

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    byteValid |=> !byteValid);

  // R6
  first_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    firstByte |-> byteValid);

  // R7
  stop_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frameStop |=> !frameStop);

  // R7
  stop_released_chk: assert property (@(posedge clk) disable iff (rst)
    frameStop |-> (!sdaPullLow && !byteValid));

  // R10
  ack_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdaPullLow) |-> !sclLvl);
endmodule

bind i2cw_rx_slave i2cw_rx_checker chk_i (
  .clk(clk),
  .rst(rst),
  .sclLvl(sclLvl),
  .sdaPullLow(sdaPullLow),
  .byteValid(byteValid),
  .firstByte(firstByte),
  .frameStop(frameStop)
);

// File: tb/i2cw_rx_slave_tb_top.sv
`timescale 1ns/1ps
module i2cw_rx_slave_tb_top;
  localparam int Q = 6;
  localparam int WATCHDOG = 195000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclBus = 1'b1;
  logic sdaDrv = 1'b1;
  logic [1:0] strap = 2'b00;
  logic sdaBus;
  logic sdaPullLow, byteValid, firstByte, frameStop;
  logic [7:0] byteData;

  int checks = 0;
  int fails = 0;
  int rxCnt = 0;
  int stopCnt = 0;
  int pullViol = 0;
  logic pullPrev = 1'b0;
  logic [7:0] rxData [16];
  logic rxFirst [16];
  bit timedOut = 1'b0;

  always #10 clk = ~clk;

  assign sdaBus = sdaDrv & ~sdaPullLow;

  i2cw_rx_slave dut_i (
    .clk(clk),
    .rst(rst),
    .sclIn(sclBus),
    .sdaIn(sdaBus),
    .addrStrap(strap),
    .sdaPullLow(sdaPullLow),
    .byteData(byteData),
    .byteValid(byteValid),
    .firstByte(firstByte),
    .frameStop(frameStop)
  );

  // Output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (byteValid) begin
        rxData[rxCnt % 16] = byteData;
        rxFirst[rxCnt % 16] = firstByte;
        rxCnt = rxCnt + 1;
      end
      if (frameStop) stopCnt = stopCnt + 1;
      if ((sdaPullLow != pullPrev) && sclBus) pullViol = pullViol + 1;
    end
    pullPrev = sdaPullLow;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; sclBus = 1'b1; waitQ();
    sdaDrv = 1'b0; waitQ();
    sclBus = 1'b0; waitQ();
  endtask

  task automatic repStart();
    sdaDrv = 1'b1; waitQ();
    sclBus = 1'b1; waitQ();
    sdaDrv = 1'b0; waitQ();
    sclBus = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; waitQ();
    sclBus = 1'b1; waitQ();
    sdaDrv = 1'b1; waitQ(); waitQ();
  endtask

  task automatic sendBit(input logic b);
    sdaDrv = b; waitQ();
    sclBus = 1'b1; waitQ(); waitQ();
    sclBus = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] v, output int ack);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    sdaDrv = 1'b1; waitQ();
    sclBus = 1'b1; waitQ();
    ack = sdaBus ? 0 : 1;
    waitQ();
    sclBus = 1'b0; waitQ();
  endtask

  // One address byte plus one data byte; expectations from the address rule
  task automatic txn(input logic [7:0] addrByte, input logic [7:0] dataByte);
    int a1, a2, base, sbase, hit;
    hit = (addrByte[7:3] == 5'b10101 && addrByte[2:1] == strap && !addrByte[0]) ? 1 : 0;
    base = rxCnt; sbase = stopCnt;
    busStart();
    sendByte(addrByte, a1);
    check(hit ? "R2" : "R3", $sformatf("addr %02h ack", addrByte), a1, hit);
    sendByte(dataByte, a2);
    check(hit ? "R5" : "R3", $sformatf("data ack after %02h", addrByte), a2, hit);
    busStop();
    check(hit ? "R4" : "R3", $sformatf("strobes after %02h", addrByte), rxCnt - base, hit);
    if (hit) begin
      check("R4", "data value", int'(rxData[base % 16]), int'(dataByte));
      check("R6", "first flag", int'(rxFirst[base % 16]), 1);
    end
    check("R7", $sformatf("stop pulses after %02h", addrByte), stopCnt - sbase, hit);
  endtask

  task automatic runTests();
    int ack, base, sbase;
    logic [7:0] multi [4];
    // R1: reset state
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "pull after reset", int'(sdaPullLow), 0);
    check("R1", "valid after reset", int'(byteValid), 0);
    check("R1", "stop after reset", int'(frameStop), 0);

    // Sweep all 7-bit addresses (write) for strap 2
    strap = 2'b10;
    for (int a = 0; a < 128; a++) txn({a[6:0], 1'b0}, 8'((a * 37 + 11) & 8'hFF));

    // Each strap against the four prefix addresses, plus its read variant
    for (int s = 0; s < 4; s++) begin
      strap = s[1:0];
      for (int lo = 0; lo < 4; lo++) txn({5'b10101, lo[1:0], 1'b0}, 8'(8'hC3 ^ lo));
      txn({5'b10101, s[1:0], 1'b1}, 8'h5A);
    end

    // R4 R5 R6: multi-byte frame, strap 1 => address byte AA
    strap = 2'b01;
    multi[0] = 8'h00; multi[1] = 8'hFF; multi[2] = 8'hA5; multi[3] = 8'h3C;
    base = rxCnt; sbase = stopCnt;
    busStart();
    sendByte(8'hAA, ack); check("R2", "multi addr ack", ack, 1);
    for (int k = 0; k < 4; k++) begin
      sendByte(multi[k], ack);
      check("R5", $sformatf("multi byte %0d ack", k), ack, 1);
    end
    busStop();
    check("R4", "multi strobe count", rxCnt - base, 4);
    for (int k = 0; k < 4; k++) begin
      check("R4", $sformatf("multi byte %0d value", k), int'(rxData[(base + k) % 16]), int'(multi[k]));
      check("R6", $sformatf("multi byte %0d first", k), int'(rxFirst[(base + k) % 16]), (k == 0) ? 1 : 0);
    end
    check("R7", "multi stop pulses", stopCnt - sbase, 1);

    // R8: repeated START to the same address
    base = rxCnt; sbase = stopCnt;
    busStart();
    sendByte(8'hAA, ack);
    sendByte(8'h11, ack);
    repStart();
    check("R8", "no stop pulse on Sr", stopCnt - sbase, 0);
    sendByte(8'hAA, ack); check("R8", "re-address ack", ack, 1);
    sendByte(8'h22, ack);
    busStop();
    check("R8", "Sr strobe count", rxCnt - base, 2);
    check("R8", "Sr second byte value", int'(rxData[(base + 1) % 16]), 8'h22);
    check("R8", "Sr re-armed first", int'(rxFirst[(base + 1) % 16]), 1);
    check("R7", "Sr stop pulses", stopCnt - sbase, 1);

    // R8: repeated START to a non-matching address
    base = rxCnt; sbase = stopCnt;
    busStart();
    sendByte(8'hAA, ack);
    sendByte(8'h33, ack);
    repStart();
    sendByte(8'hAC, ack); check("R8", "foreign Sr addr ack", ack, 0);
    sendByte(8'h44, ack); check("R3", "foreign Sr data ack", ack, 0);
    busStop();
    check("R3", "foreign Sr strobes", rxCnt - base, 1);
    check("R7", "foreign Sr stop pulses", stopCnt - sbase, 0);

    // R9: STOP in the middle of a data byte
    base = rxCnt; sbase = stopCnt;
    busStart();
    sendByte(8'hAA, ack);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    busStop();
    check("R9", "stop mid-byte strobes", rxCnt - base, 0);
    check("R7", "stop mid-byte pulses", stopCnt - sbase, 1);

    // R9: START in the middle of a data byte
    base = rxCnt;
    busStart();
    sendByte(8'hAA, ack);
    for (int k = 0; k < 5; k++) sendBit(k[0]);
    repStart();
    sendByte(8'hAA, ack);
    sendByte(8'h77, ack);
    busStop();
    check("R9", "start mid-byte strobes", rxCnt - base, 1);
    check("R9", "start mid-byte value", int'(rxData[base % 16]), 8'h77);

    // R9: STOP in the middle of the address byte
    base = rxCnt; sbase = stopCnt;
    busStart();
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    busStop();
    check("R9", "stop mid-address strobes", rxCnt - base, 0);
    check("R9", "stop mid-address pulses", stopCnt - sbase, 0);

    // R1: reset while the address ACK is driven
    sbase = stopCnt;
    busStart();
    for (int i = 7; i >= 0; i--) sendBit(1'(8'hAA >> i));
    sdaDrv = 1'b1; waitQ();
    check("R2", "ack driven before reset", int'(sdaPullLow), 1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "pull released by reset", int'(sdaPullLow), 0);
    sclBus = 1'b1; waitQ(); sclBus = 1'b0; waitQ();
    busStop();
    check("R1", "no stop pulse after reset", stopCnt - sbase, 0);

    // R10: ACK drive only moved while SCL low
    check("R10", "pull changes while SCL high", pullViol, 0);
  endtask

  initial begin
    fork
      runTests();
      begin
        repeat (WATCHDOG) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule